// File: doc/BRIEF.md
# Audio DMA Controller Register Block

This block is the register front end of a three-channel audio DMA controller with two playback channels and one capture channel. It holds four registers. The control word enables the channels. The serial-control word carries the per-channel interrupt enables and the pause bits. The memory-page nibble is used to reach per-channel buffer registers. The status word reports interrupt state to software. Software reaches the registers through a 256-byte I/O window with byte, halfword and word accesses. The write data is right-justified, and read data comes back right-justified in the same way.

Accesses that fall in the paged window have the page number folded into a 12-bit effective address. The channel engines outside this block decode that address for their frame registers. When an engine needs service, it pulses a set input. This block then keeps the pending bits, forms a summary bit from them, and drives a single interrupt line. It also tells each engine whether it may run.

Top module: `audio_csr`

## Requirements
- R1: After reset, control, serial control, page and every pending bit are zero, the interrupt output is low, and every register reads zero.
- R2: A word at byte offset 0x00 is control and a word at 0x20 is serial control; both read back what was written. The status word at 0x04 is read-only, and writes to it change nothing.
- R3: Byte writes to control or serial control replace only the addressed lane. Halfword writes at +0 or +2 replace the low or high 16 bits. Reads return the register shifted right by eight times the lane and masked to the access size. A halfword at an odd offset, or a word at an offset that is not a multiple of four, is ignored on write and reads zero.
- R4: The page register at 0x0C stores only bits 3:0 of a write to lane 0. It reads back zero-extended.
- R5: `effAddr` equals `page<<8 | busAddr` when busAddr is in 0x30..0x3F, and equals busAddr zero-extended otherwise.
- R6: Reads of any offset other than the four registers return zero, and this includes the paged window.
- R7: A pulse on `chanSet[c]` sets status bit c only if that channel's interrupt enable is 1 at that edge. Bit 2 is the first playback channel with enable bit 8. Bit 1 is the second playback channel with enable bit 9. Bit 0 is capture with enable bit 10.
- R8: Status bit 31 is the OR of status bits 2:0, and `irq` follows that OR. All other status bits read zero.
- R9: A serial-control write that takes an interrupt enable from 1 to 0 clears that channel's pending bit. The clear wins over a set in the same cycle. Setting the enable again does not bring the pending bit back.
- R10: `chanRun[2]` = control bit 6 AND NOT serial bit 11. `chanRun[1]` = control bit 5 AND NOT serial bit 12. `chanRun[0]` = control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset in the I/O window |
| busSize | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| busWdata | input | 32 | Write data, right-justified |
| busRdata | output | 32 | Read data, right-justified, combinational |
| effAddr | output | ADDR_W+PAGE_W | Page-folded effective address |
| chanSet | input | NUM_CH | Per-channel pending set pulses |
| chanRun | output | NUM_CH | Per-channel run permission |
| ctlOut | output | 32 | Control register contents |
| sctlOut | output | 32 | Serial-control register contents |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `busSize` never carries the reserved value 3. They also assume that `chanSet` is a clean per-cycle pulse, never X, while reset is released. The status-write property further assumes that no set pulse lands in the same cycle as the write. The stimulus uses only the three defined sizes and raises set pulses only in cycles of their own, with one deliberate exception: a serial-control write that collides with a set pulse, so that the clear-wins ordering is exercised. The bench samples every result one cycle after the access that causes it.

// File: rtl/audio_csr_pkg.sv
package audio_csr_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // byte offsets of the local registers
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_PAGE = 'h0C;
  localparam int OFS_SCTL = 'h20;

  // paged window bounds
  localparam int PAGED_LO = 'h30;
  localparam int PAGED_HI = 'h3F;

  // bit positions (channel index c: 0 capture, 1 playback B, 2 playback A)
  localparam int CTL_EN_LSB      = 4;   // control enable = CTL_EN_LSB + c
  localparam int SCTL_INTEN_MSB  = 10;  // int enable = SCTL_INTEN_MSB - c
  localparam int SCTL_PAUSE_B    = 12;  // pause = SCTL_PAUSE_B + 1 - c, c >= 1

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_CTL  = 3'd1,
    RD_STAT = 3'd2,
    RD_PAGE = 3'd3,
    RD_SCTL = 3'd4
  } rd_sel_e;

  typedef struct packed {
    logic [LANES-1:0] ctlLane;
    logic [LANES-1:0] sctlLane;
    logic             pageWr;
    rd_sel_e          rdSel;
    logic [1:0]       laneOfs;
    acc_size_e        rdSize;
  } csr_strobe_t;

endpackage

// File: rtl/audio_csr_dec.sv
module audio_csr_dec
  import audio_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  localparam int EFF_W = ADDR_W + PAGE_W
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [PAGE_W-1:0] pageVal,
  output logic [EFF_W-1:0]  effAddr,
  output csr_strobe_t       strobe
);

  localparam int IDX_W = EFF_W - 2;
  localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(OFS_CTL  >> 2);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(OFS_STAT >> 2);
  localparam logic [IDX_W-1:0] IDX_PAGE = IDX_W'(OFS_PAGE >> 2);
  localparam logic [IDX_W-1:0] IDX_SCTL = IDX_W'(OFS_SCTL >> 2);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(PAGED_LO);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(PAGED_HI);

  acc_size_e        sizeE;
  logic             aligned;
  logic [LANES-1:0] laneBits;
  logic             inPaged;
  logic [IDX_W-1:0] wordIdx;
  logic             doWr;
  logic             doRd;

  assign sizeE = acc_size_e'(busSize);

  always_comb begin
    aligned  = 1'b0;
    laneBits = '0;
    unique case (sizeE)
      SZ_BYTE: begin
        aligned  = 1'b1;
        laneBits = LANES'(1) << busAddr[1:0];
      end
      SZ_HALF: begin
        aligned  = ~busAddr[0];
        laneBits = LANES'(3) << busAddr[1:0];
      end
      SZ_WORD: begin
        aligned  = (busAddr[1:0] == 2'b00);
        laneBits = '1;
      end
      default: begin
        aligned  = 1'b0;
        laneBits = '0;
      end
    endcase
  end

  // fold page number into the paged window
  assign inPaged = (busAddr >= WIN_LO) && (busAddr <= WIN_HI);
  assign effAddr = inPaged ? {pageVal, busAddr} : {{PAGE_W{1'b0}}, busAddr};
  assign wordIdx = effAddr[EFF_W-1:2];

  assign doWr = busValid && aligned && busWrite;
  assign doRd = busValid && aligned && !busWrite;

  always_comb begin
    strobe          = '0;
    strobe.laneOfs  = busAddr[1:0];
    strobe.rdSize   = sizeE;
    strobe.rdSel    = RD_NONE;
    if (doWr) begin
      if (wordIdx == IDX_CTL)  strobe.ctlLane  = laneBits;
      if (wordIdx == IDX_SCTL) strobe.sctlLane = laneBits;
      if (wordIdx == IDX_PAGE) strobe.pageWr   = laneBits[0];
    end
    if (doRd) begin
      if      (wordIdx == IDX_CTL)  strobe.rdSel = RD_CTL;
      else if (wordIdx == IDX_STAT) strobe.rdSel = RD_STAT;
      else if (wordIdx == IDX_PAGE) strobe.rdSel = RD_PAGE;
      else if (wordIdx == IDX_SCTL) strobe.rdSel = RD_SCTL;
    end
  end

endmodule

// File: rtl/audio_csr_regs.sv
module audio_csr_regs
  import audio_csr_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_CH-1:0] chanSet,
  output logic [DATA_W-1:0] busRdata,
  output logic [PAGE_W-1:0] pageVal,
  output logic [DATA_W-1:0] ctlQ,
  output logic [DATA_W-1:0] sctlQ,
  output logic [NUM_CH-1:0] pendBits,
  output logic [NUM_CH-1:0] chanRun,
  output logic              irq
);

  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] ctlNext;
  logic [DATA_W-1:0] sctlNext;
  logic [NUM_CH-1:0] pendNext;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] regVal;
  logic [DATA_W-1:0] sizeMask;
  logic              anyPend;

  assign laneData = busWdata << {strobe.laneOfs, 3'b000};

  // byte-lane merge
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ctlNext[8*i +: 8]  = strobe.ctlLane[i]  ? laneData[8*i +: 8] : ctlQ[8*i +: 8];
    assign sctlNext[8*i +: 8] = strobe.sctlLane[i] ? laneData[8*i +: 8] : sctlQ[8*i +: 8];
  end

  // pending bits: clear on enable falling edge wins over a set
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int EN_POS = SCTL_INTEN_MSB - c;
    logic enOld;
    logic enDrop;
    assign enOld       = sctlQ[EN_POS];
    assign enDrop      = enOld && !sctlNext[EN_POS];
    assign pendNext[c] = (pendBits[c] | (chanSet[c] & enOld)) & ~enDrop;

    if (c == 0) begin : g_nopause
      assign chanRun[c] = ctlQ[CTL_EN_LSB + c];
    end else begin : g_pause
      assign chanRun[c] = ctlQ[CTL_EN_LSB + c] && !sctlQ[SCTL_PAUSE_B + 1 - c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ     <= '0;
      sctlQ    <= '0;
      pageVal  <= '0;
      pendBits <= '0;
    end else begin
      ctlQ     <= ctlNext;
      sctlQ    <= sctlNext;
      pendBits <= pendNext;
      if (strobe.pageWr) pageVal <= busWdata[PAGE_W-1:0];
    end
  end

  assign anyPend    = |pendBits;
  assign irq        = anyPend;
  assign statusWord = {anyPend, {(DATA_W-1-NUM_CH){1'b0}}, pendBits};

  always_comb begin
    unique case (strobe.rdSel)
      RD_CTL:  regVal = ctlQ;
      RD_STAT: regVal = statusWord;
      RD_PAGE: regVal = {{(DATA_W-PAGE_W){1'b0}}, pageVal};
      RD_SCTL: regVal = sctlQ;
      default: regVal = '0;
    endcase
    unique case (strobe.rdSize)
      SZ_BYTE: sizeMask = DATA_W'(32'h0000_00FF);
      SZ_HALF: sizeMask = DATA_W'(32'h0000_FFFF);
      default: sizeMask = '1;
    endcase
  end

  assign busRdata = (regVal >> {strobe.laneOfs, 3'b000}) & sizeMask;

endmodule

// File: rtl/audio_csr.sv
module audio_csr
  import audio_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int NUM_CH = 3,
  localparam int EFF_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [EFF_W-1:0]  effAddr,
  input  logic [NUM_CH-1:0] chanSet,
  output logic [NUM_CH-1:0] chanRun,
  output logic [31:0]       ctlOut,
  output logic [31:0]       sctlOut,
  output logic              irq
);

  csr_strobe_t       strobe;
  logic [PAGE_W-1:0] pageVal;
  logic [NUM_CH-1:0] pendBits;

  audio_csr_dec #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_dec (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .pageVal (pageVal),
    .effAddr (effAddr),
    .strobe  (strobe)
  );

  audio_csr_regs #(
    .PAGE_W(PAGE_W),
    .NUM_CH(NUM_CH)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .chanSet (chanSet),
    .busRdata(busRdata),
    .pageVal (pageVal),
    .ctlQ    (ctlOut),
    .sctlQ   (sctlOut),
    .pendBits(pendBits),
    .chanRun (chanRun),
    .irq     (irq)
  );

endmodule

// File: rtl/audio_csr_chk.sv
module audio_csr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [31:0]       busRdata,
  input logic [2:0]        chanSet,
  input logic [2:0]        intEn,
  input logic [2:0]        pendBits,
  input logic              irq
);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(intEn) != 3'b000)); // R7

  AST_PEND_A_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendBits[2]) |-> $past(intEn[0])); // R7

  AST_IRQ_LOW_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == 3'b000) |-> !irq); // R9

  AST_DROP_CLEARS_A: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intEn[0]) |-> !pendBits[2]); // R9

  AST_DROP_CLEARS_B: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intEn[1]) |-> !pendBits[1]); // R9

  AST_DROP_CLEARS_CAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intEn[2]) |-> !pendBits[0]); // R9

  AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr[ADDR_W-1:2] == (ADDR_W-2)'(1) && chanSet == 3'b000)
      |=> $stable(irq)); // R2

  AST_MISALIGNED_WORD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busSize == 2'd2 && busAddr[1:0] != 2'b00)
      |-> (busRdata == 32'h0)); // R3

endmodule

bind audio_csr audio_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busSize (busSize),
  .busRdata(busRdata),
  .chanSet (chanSet),
  .intEn   (sctlOut[10:8]),
  .pendBits(pendBits),
  .irq     (irq)
);

// File: tb/audio_csr_tb.sv
module audio_csr_tb;

  localparam int K_RD  = 0;
  localparam int K_IRQ = 1;
  localparam int K_RUN = 2;
  localparam int K_EFF = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [11:0] effAddr;
  logic [2:0]  chanSet = '0;
  logic [2:0]  chanRun;
  logic [31:0] ctlOut;
  logic [31:0] sctlOut;
  logic        irq;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  audio_csr u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .effAddr (effAddr),
    .chanSet (chanSet),
    .chanRun (chanRun),
    .ctlOut  (ctlOut),
    .sctlOut (sctlOut),
    .irq     (irq)
  );

  // monitor: compare queued expectations one step after the edge
  always @(posedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = busRdata;
        K_IRQ:   act = {31'b0, irq};
        K_RUN:   act = {29'b0, chanRun};
        default: act = {20'b0, effAddr};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic drive(input logic v, input logic w, input logic [7:0] a,
                       input logic [1:0] s, input logic [31:0] d, input logic [2:0] set);
    @(negedge clk);
    busValid = v;
    busWrite = w;
    busAddr  = a;
    busSize  = s;
    busWdata = d;
    chanSet  = set;
  endtask

  task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    drive(1'b1, 1'b1, a, s, d, 3'b000);
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp,
                    input string tag);
    drive(1'b1, 1'b0, a, s, '0, 3'b000);
    expect_item(K_RD, exp, tag);
  endtask

  task automatic pulse(input logic [2:0] set);
    drive(1'b0, 1'b0, '0, '0, '0, set);
  endtask

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    drive(1'b0, 1'b0, '0, '0, '0, 3'b000);
    expect_item(kind, exp, tag);
  endtask

  task automatic chk_eff(input logic [7:0] a, input logic [31:0] expAddr, input string tag);
    drive(1'b1, 1'b0, a, 2'd2, '0, 3'b000);
    expect_item(K_EFF, expAddr, tag);
    expect_item(K_RD, 32'h0, {tag, " R6 read zero"});
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, 2'd2, 32'h0, "R1 ctl after reset");
    rd(8'h04, 2'd2, 32'h0, "R1 status after reset");
    rd(8'h20, 2'd2, 32'h0, "R1 sctl after reset");
    rd(8'h0C, 2'd2, 32'h0, "R1 page after reset");
    chk(K_IRQ, 32'h0, "R1 irq after reset");

    // R2 word access
    wr(8'h00, 2'd2, 32'h1234_5678);
    rd(8'h00, 2'd2, 32'h1234_5678, "R2 ctl word");
    wr(8'h20, 2'd2, 32'h0000_0000);
    rd(8'h20, 2'd2, 32'h0, "R2 sctl word");

    // R3 lane merging and read alignment
    wr(8'h02, 2'd0, 32'h0000_00AB);
    rd(8'h00, 2'd2, 32'h12AB_5678, "R3 byte write lane 2");
    rd(8'h03, 2'd0, 32'h0000_0012, "R3 byte read lane 3");
    rd(8'h02, 2'd1, 32'h0000_12AB, "R3 half read +2");
    wr(8'h02, 2'd1, 32'h0000_CAFE);
    rd(8'h00, 2'd2, 32'hCAFE_5678, "R3 half write +2");
    wr(8'h01, 2'd1, 32'h0000_FFFF);
    rd(8'h00, 2'd2, 32'hCAFE_5678, "R3 odd half write ignored");
    rd(8'h01, 2'd1, 32'h0, "R3 odd half read zero");
    wr(8'h02, 2'd2, 32'hFFFF_FFFF);
    rd(8'h00, 2'd2, 32'hCAFE_5678, "R3 unaligned word write ignored");

    // R2 status read-only
    wr(8'h04, 2'd2, 32'hFFFF_FFFF);
    rd(8'h04, 2'd2, 32'h0, "R2 status write ignored");
    chk(K_IRQ, 32'h0, "R2 irq after status write");

    // R4 page register
    wr(8'h0C, 2'd2, 32'hFFFF_FFF5);
    rd(8'h0C, 2'd2, 32'h0000_0005, "R4 page keeps nibble");
    wr(8'h0C, 2'd0, 32'h0000_003A);
    rd(8'h0C, 2'd0, 32'h0000_000A, "R4 page byte write");

    // R5 / R6 paged window
    chk_eff(8'h34, 32'h0000_0A34, "R5 paged 0x34");
    chk_eff(8'h30, 32'h0000_0A30, "R5 paged low edge");
    chk_eff(8'h3F, 32'h0000_0A3F, "R5 paged high edge");
    chk_eff(8'h2F, 32'h0000_002F, "R5 below window");
    chk_eff(8'h40, 32'h0000_0040, "R5 above window");
    rd(8'h10, 2'd2, 32'h0, "R6 undecoded 0x10");

    // R7 set needs enable
    pulse(3'b111);
    rd(8'h04, 2'd2, 32'h0, "R7 set ignored without enable");
    chk(K_IRQ, 32'h0, "R7 irq low without enable");
    wr(8'h20, 2'd2, 32'h0000_0700);
    pulse(3'b100);
    rd(8'h04, 2'd2, 32'h8000_0004, "R7 R8 first playback pending");
    chk(K_IRQ, 32'h1, "R8 irq high");
    pulse(3'b001);
    rd(8'h04, 2'd2, 32'h8000_0005, "R7 R8 capture pending");

    // R9 clear on enable drop
    wr(8'h21, 2'd0, 32'h0000_0006);
    rd(8'h04, 2'd2, 32'h8000_0001, "R9 drop bit8 clears bit2 only");
    wr(8'h21, 2'd0, 32'h0000_0002);
    rd(8'h04, 2'd2, 32'h0, "R9 drop bit10 clears capture");
    chk(K_IRQ, 32'h0, "R8 irq low after clear");
    pulse(3'b010);
    rd(8'h04, 2'd2, 32'h8000_0002, "R7 second playback pending");
    drive(1'b1, 1'b1, 8'h20, 2'd2, 32'h0, 3'b010);
    rd(8'h04, 2'd2, 32'h0, "R9 clear wins over set");
    wr(8'h20, 2'd2, 32'h0000_0200);
    rd(8'h04, 2'd2, 32'h0, "R9 re-enable keeps clear");

    // R10 run permission
    chk(K_RUN, 32'h7, "R10 all running");
    wr(8'h20, 2'd2, 32'h0000_1A00);
    chk(K_RUN, 32'h1, "R10 both playback paused");
    rd(8'h21, 2'd0, 32'h0000_001A, "R3 sctl byte read");
    wr(8'h00, 2'd0, 32'h0000_0020);
    chk(K_RUN, 32'h0, "R10 capture off playback paused");
    wr(8'h20, 2'd2, 32'h0);
    chk(K_RUN, 32'h2, "R10 second playback runs");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule